// File: doc/BRIEF.md
# Synchronized PWM Timer Group

The block holds one master timer and a parameterizable number of slave timers, all running on one clock. Each timer is an up-counter with a period value, a compare value and a PWM output that is high while the count is below the compare value. The master emits a one-clock trigger each time its counter wraps. The trigger passes through a resynchronizing register stage and is then shared by every slave.

Each slave uses the trigger in one of four ways. It can ignore it. It can count only while the trigger is high. It can restart its count on a trigger edge. It can wait stopped until a trigger edge enables it. The count a slave takes on a trigger edge is programmable, so one clock of resynchronization delay can be cancelled and the slave brought into exact phase with the master. Period and compare values are double-buffered and change only on an update event.

Software programs the timers through one synchronous write port. The port has a timer index, a register select and a data word. Timer 0 is the master, and its slave-mode setting has no effect.

Top module: `sync_pwm_group`

## Requirements
- R1: A running counter steps 0,1,..,P and then returns to 0, where P is the active period value, so it repeats every P+1 clocks.
- R2: Each bit of pwm_o is 1 exactly while that timer's count is less than its active compare value.
- R3: upd_o[0] is high for one clock in each cycle in which the running master counter holds its period value. This is the master's trigger.
- R4: In slave mode 1 (gated), an enabled slave advances only in cycles where the resynchronized trigger is high. Otherwise its count and output stay frozen.
- R5: In slave mode 2 (restart), a rising edge of the resynchronized trigger loads an enabled slave's count with its start value and counts as an update event.
- R6: In slave mode 3 (trigger), a stopped slave stays at count 0 until a resynchronized trigger edge. It then sets its own enable and takes its start value. With start value 1, every such slave's pwm_o bit equals the master's bit on every later cycle.
- R7: The trigger reaches slaves one clock after the master's wrap. With start value 0, a trigger-mode slave's output equals the master's output one clock earlier.
- R8: A trigger-mode slave enabled by a register write runs freely and is not realigned by later triggers.
- R9: Period and compare writes to a running timer take effect at its next update event, including a write made in the update cycle itself. While a timer is stopped they take effect at once.
- R10: In slave mode 0 (free), a slave ignores the trigger and counts whenever enabled.
- R11: Writing 0 to a timer's enable stops its counter, and its pwm_o bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_tmr_i | input | $clog2(N_SLV+1) | Timer index: 0 master, 1..N_SLV slaves |
| wr_sel_i | input | 3 | Register: 0 period, 1 compare, 2 start value, 3 slave mode (data[1:0]), 4 enable (data[0]) |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | N_SLV+1 | PWM output per timer, bit 0 the master |
| upd_o | output | N_SLV+1 | Update event per timer; bit 0 is the master trigger |

## Verification
The embedded assertions check several rules on every cycle. A wrapping counter returns to zero. A gated slave holds its count while the trigger is low. A stopped timer holds its count. A restart or trigger edge loads the start value. Active period and compare values change only on an update. The master's trigger stays one clock wide. Phase relations between timers can only be shown by the bench scenarios: exact alignment with start value 1, a one-clock lag with start value 0, the restart pattern, and the length of the periods around a shadow write.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef enum logic [1:0] {
    SM_FREE    = 2'd0,
    SM_GATED   = 2'd1,
    SM_RESTART = 2'd2,
    SM_TRIGGER = 2'd3
  } slave_mode_e;

  typedef enum logic [2:0] {
    RS_PERIOD  = 3'd0,
    RS_COMPARE = 3'd1,
    RS_START   = 3'd2,
    RS_MODE    = 3'd3,
    RS_ENABLE  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/trig_resync.sv
module trig_resync #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] pipe_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= trig_i;
      for (int s = 1; s < SYNC_STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import sync_pwm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit IS_MASTER = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             trig_lvl_i,
  input  logic             trig_rise_i,
  output logic             upd_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] per_pre_q, per_act_q, cmp_pre_q, cmp_act_q, start_q, cnt_q;
  slave_mode_e      mode_q, mode_eff;
  logic             en_q, tick, wrap, restart, arm, upd, en_wr;

  assign mode_eff = IS_MASTER ? SM_FREE : mode_q;
  assign tick     = en_q && (mode_eff != SM_GATED || trig_lvl_i);
  assign wrap     = tick && (cnt_q >= per_act_q);
  assign restart  = en_q && (mode_eff == SM_RESTART) && trig_rise_i;
  assign arm      = !en_q && (mode_eff == SM_TRIGGER) && trig_rise_i;
  assign upd      = wrap || restart;
  assign en_wr    = wr_en_i && (reg_sel_e'(wr_sel_i) == RS_ENABLE);

  // register file (preload side)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_pre_q <= '0;
      cmp_pre_q <= '0;
      start_q   <= '0;
      mode_q    <= SM_FREE;
      en_q      <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (reg_sel_e'(wr_sel_i))
          RS_PERIOD:  per_pre_q <= wr_data_i;
          RS_COMPARE: cmp_pre_q <= wr_data_i;
          RS_START:   start_q   <= wr_data_i;
          RS_MODE:    mode_q    <= slave_mode_e'(wr_data_i[1:0]);
          default: ;
        endcase
      end
      if (en_wr)    en_q <= wr_data_i[0];
      else if (arm) en_q <= 1'b1;
    end
  end

  // shadows: transparent while stopped, else loaded on update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_act_q <= '0;
      cmp_act_q <= '0;
    end else if (!en_q || upd) begin
      per_act_q <= per_pre_q;
      cmp_act_q <= cmp_pre_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart || arm)  cnt_q <= start_q;
    else if (wrap)            cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end

  assign upd_o = upd;
  assign pwm_o = cnt_q < cmp_act_q;

  assert_wrap_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !restart) |=> cnt_q == '0);
  assert_trig_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_MASTER && wrap && per_act_q != '0) |=> (!wrap || per_act_q == '0));
  assert_gate_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_eff == SM_GATED && !trig_lvl_i) |=> $stable(cnt_q));
  assert_restart_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> cnt_q == $past(start_q));
  assert_arm_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !en_wr) |=> (en_q && cnt_q == $past(start_q)));
  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !upd) |=> ($stable(per_act_q) && $stable(cmp_act_q)));
  assert_stop_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !arm) |=> $stable(cnt_q));
endmodule

// File: rtl/sync_pwm_group.sv
module sync_pwm_group
  import sync_pwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_SLV       = 2,
  parameter int SYNC_STAGES = 1,
  localparam int N_TMR      = N_SLV + 1,
  localparam int SEL_W      = $clog2(N_TMR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_tmr_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [N_TMR-1:0] pwm_o,
  output logic [N_TMR-1:0] upd_o
);
  logic trig_lvl, trig_rise;

  trig_resync #(.SYNC_STAGES(SYNC_STAGES)) u_resync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (upd_o[0]),
    .lvl_o  (trig_lvl),
    .rise_o (trig_rise)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam bit MASTER = (i == 0);
    pwm_timer_core #(.CNT_W(CNT_W), .IS_MASTER(MASTER)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i && (wr_tmr_i == SEL_W'(i))),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .trig_lvl_i  (MASTER ? 1'b0 : trig_lvl),
      .trig_rise_i (MASTER ? 1'b0 : trig_rise),
      .upd_o       (upd_o[i]),
      .pwm_o       (pwm_o[i])
    );
  end
endmodule

// File: tb/sync_pwm_group_bench.sv
`timescale 1ns/1ps
module sync_pwm_group_bench;
  localparam int CNT_W = 16;
  localparam int N_SLV = 2;
  localparam int N_TMR = N_SLV + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_tmr = '0;
  logic [2:0]       wr_sel = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [N_TMR-1:0] pwm, upd;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_pwm_group #(.CNT_W(CNT_W), .N_SLV(N_SLV)) u_sync_pwm_group (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_tmr_i(wr_tmr),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .pwm_o(pwm), .upd_o(upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int t, input int s, input int d);
    wr_tmr = 2'(t); wr_sel = 3'(s); wr_data = CNT_W'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int t, input int per, input int cmp, input int st, input int md);
    wr(t, 0, per); wr(t, 1, cmp); wr(t, 2, st); wr(t, 3, md);
  endtask

  task automatic wait_trig();
    while (!upd[0]) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(pwm == '0, "R2 reset pwm", int'(pwm), 0);
    chk(upd == '0, "R3 reset upd", int'(upd), 0);
  endtask

  // master free run, slave1 free mode ignoring trigger
  task automatic t_free();
    int bad_m = 0, bad_u = 0, bad_s = 0;
    do_reset();
    cfg(0, 7, 4, 0, 0);
    cfg(1, 5, 2, 0, 0);
    wr(1, 4, 1);
    wr(0, 4, 1);
    for (int k = 1; k <= 40; k++) begin
      if (pwm[0] != (((k-1)%8) < 4)) bad_m++;
      if (upd[0] != (((k-1)%8) == 7)) bad_u++;
      if (pwm[1] != ((k%6) < 2)) bad_s++;
      @(negedge clk);
    end
    chk(bad_m == 0, "R1 R2 master pwm pattern", bad_m, 0);
    chk(bad_u == 0, "R3 master trigger pulse", bad_u, 0);
    chk(bad_s == 0, "R10 free slave ignores trigger", bad_s, 0);
  endtask

  task automatic t_gated();
    int bad_f = 0, bad_g = 0;
    do_reset();
    cfg(1, 1, 1, 0, 1);
    wr(1, 4, 1);
    cfg(0, 7, 4, 0, 0);
    for (int k = 0; k < 30; k++) begin
      if (pwm[1] != 1'b1) bad_f++;
      @(negedge clk);
    end
    chk(bad_f == 0, "R4 gated slave frozen without trigger", bad_f, 0);
    wr(0, 4, 1);
    for (int k = 1; k <= 25; k++) begin
      if (pwm[1] != !(k >= 10 && k <= 17)) bad_g++;
      @(negedge clk);
    end
    chk(bad_g == 0, "R4 gated slave steps once per trigger", bad_g, 0);
  endtask

  task automatic t_trigger(input int st);
    int bad_w = 0, bad_a = 0;
    bit prev_m = 1'b0;
    do_reset();
    cfg(1, 7, 4, st, 3);
    cfg(2, 7, 4, st, 3);
    cfg(0, 7, 4, 0, 0);
    wr(0, 4, 1);
    for (int k = 1; k <= 60; k++) begin
      if (k == 5 && !(pwm[1] && pwm[2] && !pwm[0])) bad_w++;
      if (st == 1 && k >= 10 && !(pwm[1] == pwm[0] && pwm[2] == pwm[0])) bad_a++;
      if (st == 0 && k >= 11 && !(pwm[1] == prev_m && pwm[2] == prev_m)) bad_a++;
      prev_m = pwm[0];
      @(negedge clk);
    end
    chk(bad_w == 0, "R6 slaves wait stopped before trigger", bad_w, 0);
    if (st == 1) chk(bad_a == 0, "R6 slaves cycle-aligned with start 1", bad_a, 0);
    else         chk(bad_a == 0, "R7 slaves lag one clock with start 0", bad_a, 0);
  endtask

  task automatic t_sw_enable();
    int bad = 0;
    do_reset();
    cfg(1, 7, 4, 1, 3);
    cfg(0, 7, 4, 0, 0);
    wr(1, 4, 1);
    wr(0, 4, 1);
    for (int k = 1; k <= 40; k++) begin
      if (pwm[1] != ((k%8) < 4)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 software-enabled trigger slave free runs", bad, 0);
  endtask

  task automatic t_restart();
    int bad = 0;
    do_reset();
    cfg(1, 15, 4, 1, 2);
    cfg(0, 7, 4, 0, 0);
    wr(1, 4, 1);
    wr(0, 4, 1);
    for (int k = 1; k <= 50; k++) begin
      if (k >= 10 && pwm[1] != ((((k-10)%8)+1) < 4)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 restart slave reloads start on trigger", bad, 0);
  endtask

  task automatic t_preload();
    int hi_a = 0, hi_b = 0;
    int first = -1, second = -1;
    do_reset();
    cfg(0, 7, 4, 0, 0);
    wr(0, 4, 1);
    wait_trig();
    wr(0, 1, 2);
    for (int s = 0; s < 16; s++) begin
      if (s < 8) hi_a += int'(pwm[0]); else hi_b += int'(pwm[0]);
      @(negedge clk);
    end
    chk(hi_a == 4, "R9 compare unchanged until update", hi_a, 4);
    chk(hi_b == 2, "R9 compare applied after update", hi_b, 2);
    wait_trig();
    wr(0, 0, 3);
    for (int s = 0; s < 16; s++) begin
      if (upd[0]) begin
        if (first < 0) first = s;
        else if (second < 0) second = s;
      end
      @(negedge clk);
    end
    chk(first == 7, "R9 period unchanged until update", first, 7);
    chk(second == 11, "R1 R9 new period applied after update", second, 11);
  endtask

  task automatic t_stop();
    int bad = 0;
    do_reset();
    cfg(0, 7, 4, 0, 0);
    wr(0, 4, 1);
    wait_trig();
    repeat (2) @(negedge clk);
    wr(0, 4, 0);
    for (int k = 0; k < 20; k++) begin
      if (pwm[0] != 1'b1 || upd[0] != 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R11 stopped timer holds output", bad, 0);
  endtask

  initial begin
    t_reset();
    t_free();
    t_gated();
    t_trigger(1);
    t_trigger(0);
    t_sw_enable();
    t_restart();
    t_preload();
    t_stop();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule